// File: doc/BRIEF.md
# Packet Trace Debug Monitor

This block watches the symbol streams that pass between a radio MAC and its baseband, in both the transmit and the receive direction. It copies each packet it sees onto a two-wire serial debug port. The port is for a logic analyser or a small host receiver. The block only listens: the tap inputs are plain observations of existing wires, and the block drives nothing back toward the MAC or the baseband.

Each direction has three tap inputs: a packet-active level, a symbol strobe and a 4-bit symbol. The capture stage pairs the symbols into bytes. It places a direction tag at the head of each packet and writes the result into a small FIFO. The FIFO absorbs the difference between the fast symbol taps and the slow serial line. The serialiser sends each byte in asynchronous start/stop form, with no clock. The bit period is the system clock divided by `CLK_HZ/BIT_HZ`, which gives 500 kbit/s by default. A frame-enable wire marks the extent of each traced packet. When a packet does not fit, its tail is cut, and an error tag closes the frame.

Top module: `pkt_trace_port`

## Requirements
- R1: After reset, and whenever no frame is open, `trace_frame` is 0 and `trace_data` is 1.
- R2: Each byte on `trace_data` is a 0 start bit, then eight data bits with the least significant bit first, then a 1 stop bit. Each bit lasts DIV = CLK_HZ/BIT_HZ clock cycles (100 by default). Queued bytes of one frame follow each other with no gap, so their start bits are 10·DIV cycles apart.
- R3: `trace_frame` rises exactly DIV cycles before the start bit of the first byte of a frame. When the closing entry is already queued, `trace_frame` falls exactly DIV cycles after the end of the last stop bit, which is 11·DIV cycles after that byte's start bit.
- R4: The first byte of every frame is a direction tag: 0x01 for a transmitted packet and 0x02 for a received packet.
- R5: A packet begins on the rising edge of its active level. Symbol strobes in that first cycle are ignored. After that, each pair of strobed symbols forms one byte, with the first symbol as bits 3:0 and the second as bits 7:4.
- R6: A symbol left unpaired when the active level drops is discarded. The frame closes after the last whole byte.
- R7: If both active levels rise in the same cycle, only the transmit packet is traced.
- R8: A packet whose active level rises while another packet is being captured is not traced at all, even if it is still active after the first one ends.
- R9: The FIFO holds FIFO_DEPTH entries. A data byte is stored only while at least two entries are free, which keeps one slot for the closing entry. The first byte that finds less room, and every later byte of that packet, is dropped, and the frame then ends with the byte 0xEE. On an idle port, a packet of more than FIFO_DEPTH-1 bytes delivered back to back therefore shows its first FIFO_DEPTH-1 bytes followed by 0xEE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_act | input | 1 | Transmit packet in progress |
| tx_sym_vld | input | 1 | Transmit symbol strobe |
| tx_sym | input | 4 | Transmit symbol |
| rx_act | input | 1 | Receive packet in progress |
| rx_sym_vld | input | 1 | Receive symbol strobe |
| rx_sym | input | 4 | Receive symbol |
| trace_frame | output | 1 | Frame enable, high for the whole traced packet |
| trace_data | output | 1 | Serial trace bits, idle high |

## Verification
The serial outputs trail the taps by many cycles, so the driver does not time them. It queues the tag, data bytes and frame-end marker that the requirements predict. A monitor then times every edge against the previous one and reads each bit at mid-period. The frame rise must lead the first start edge by DIV cycles (R3), and consecutive start edges must be 10·DIV cycles apart (R2). The frame fall must come 11·DIV cycles after the last start edge. Between packets the bench waits until the queue is empty and the frame is low, so the FIFO is empty at each start and the overflow cut point in R9 is exact.

// File: rtl/pkt_trace_pkg.sv
package pkt_trace_pkg;

    // Kind of entry held in the trace FIFO
    typedef enum logic [1:0] {
        ENT_BYTE = 2'd0,
        ENT_END  = 2'd1,
        ENT_ERR  = 2'd2
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e  kind;
        logic [7:0] data;
    } trace_ent_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_SEND,
        S_WAIT,
        S_TRAIL
    } ser_state_e;

    localparam logic [7:0] TAG_TX  = 8'h01;
    localparam logic [7:0] TAG_RX  = 8'h02;
    localparam logic [7:0] TAG_ERR = 8'hEE;

    function automatic logic [7:0] join_nibbles(input logic [3:0] lo, input logic [3:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pkt_trace_fifo.sv
module pkt_trace_fifo
    import pkt_trace_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  trace_ent_t    din,
    input  logic          pop,
    output trace_ent_t    dout,
    output logic [CW-1:0] cnt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    trace_ent_t    mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
            cnt  <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pkt_trace_capture.sv
module pkt_trace_capture
    import pkt_trace_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_act,
    input  logic          tx_sym_vld,
    input  logic [3:0]    tx_sym,
    input  logic          rx_act,
    input  logic          rx_sym_vld,
    input  logic [3:0]    rx_sym,
    input  logic [CW-1:0] cnt,
    output logic          push,
    output trace_ent_t    ent
);
    logic       on_q, dir_q, half_q, drop_q, skip_q, tx_q, rx_q;
    logic [3:0] lo_q;
    logic       room, rise_tx, rise_rx, cur_act, cur_vld;
    logic [3:0] cur_sym;

    always_comb begin
        room    = (cnt <= CW'(DEPTH - 2));
        rise_tx = tx_act & ~tx_q;
        rise_rx = rx_act & ~rx_q;
        cur_act = dir_q ? rx_act     : tx_act;
        cur_vld = dir_q ? rx_sym_vld : tx_sym_vld;
        cur_sym = dir_q ? rx_sym     : tx_sym;
        push    = 1'b0;
        ent     = '0;
        if (!on_q) begin
            if ((rise_tx || rise_rx) && room) begin
                push     = 1'b1;
                ent.kind = ENT_BYTE;
                ent.data = rise_tx ? TAG_TX : TAG_RX;
            end
        end else if (!cur_act) begin
            push     = !skip_q;
            ent.kind = drop_q ? ENT_ERR : ENT_END;
        end else if (cur_vld && half_q && !drop_q && !skip_q && room) begin
            push     = 1'b1;
            ent.kind = ENT_BYTE;
            ent.data = join_nibbles(lo_q, cur_sym);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            dir_q  <= 1'b0;
            half_q <= 1'b0;
            drop_q <= 1'b0;
            skip_q <= 1'b0;
            tx_q   <= 1'b0;
            rx_q   <= 1'b0;
            lo_q   <= '0;
        end else begin
            tx_q <= tx_act;
            rx_q <= rx_act;
            if (!on_q) begin
                if (rise_tx || rise_rx) begin
                    on_q   <= 1'b1;
                    dir_q  <= !rise_tx;
                    half_q <= 1'b0;
                    drop_q <= 1'b0;
                    skip_q <= !room;
                end
            end else if (!cur_act) begin
                on_q <= 1'b0;
            end else if (cur_vld) begin
                half_q <= ~half_q;
                if (!half_q)
                    lo_q <= cur_sym;
                else if (!room && !skip_q)
                    drop_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_trace_ser.sv
module pkt_trace_ser
    import pkt_trace_pkg::*;
#(
    parameter int DIV = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       empty,
    input  trace_ent_t head,
    output logic       pop,
    output logic       frame,
    output logic       line
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(DIV - 1);

    ser_state_e    st_q;
    logic [TW-1:0] tmr_q;
    logic [3:0]    bits_q;
    logic [8:0]    sh_q;
    logic          close_q;
    logic          tick, fetch;

    always_comb begin
        tick  = (tmr_q == '0);
        fetch = (st_q == S_SEND && tick && bits_q == '0) || (st_q == S_WAIT);
        pop   = !empty && ((st_q == S_IDLE) || (fetch && !close_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            tmr_q   <= '0;
            bits_q  <= '0;
            sh_q    <= '0;
            close_q <= 1'b0;
            frame   <= 1'b0;
            line    <= 1'b1;
        end else begin
            case (st_q)
                S_IDLE: if (pop) begin
                    frame <= 1'b1;
                    sh_q  <= {1'b1, head.data};
                    tmr_q <= RELOAD;
                    st_q  <= S_LEAD;
                end
                S_LEAD: if (tick) begin
                    line   <= 1'b0;
                    bits_q <= 4'd9;
                    tmr_q  <= RELOAD;
                    st_q   <= S_SEND;
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
                S_SEND, S_WAIT: if (fetch) begin
                    if (close_q) begin
                        close_q <= 1'b0;
                        tmr_q   <= RELOAD;
                        st_q    <= S_TRAIL;
                    end else if (!empty) begin
                        if (head.kind == ENT_END) begin
                            tmr_q <= RELOAD;
                            st_q  <= S_TRAIL;
                        end else begin
                            line    <= 1'b0;
                            sh_q    <= {1'b1, (head.kind == ENT_ERR) ? TAG_ERR : head.data};
                            close_q <= (head.kind == ENT_ERR);
                            bits_q  <= 4'd9;
                            tmr_q   <= RELOAD;
                            st_q    <= S_SEND;
                        end
                    end else begin
                        st_q <= S_WAIT;
                    end
                end else if (tick) begin
                    line   <= sh_q[0];
                    sh_q   <= sh_q >> 1;
                    bits_q <= bits_q - 1'b1;
                    tmr_q  <= RELOAD;
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
                S_TRAIL: if (tick) begin
                    frame <= 1'b0;
                    st_q  <= S_IDLE;
                end else begin
                    tmr_q <= tmr_q - 1'b1;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_trace_port.sv
module pkt_trace_port
    import pkt_trace_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int BIT_HZ     = 500_000,
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_act,
    input  logic       tx_sym_vld,
    input  logic [3:0] tx_sym,
    input  logic       rx_act,
    input  logic       rx_sym_vld,
    input  logic [3:0] rx_sym,
    output logic       trace_frame,
    output logic       trace_data
);
    localparam int DIV = CLK_HZ / BIT_HZ;
    localparam int CW  = $clog2(FIFO_DEPTH + 1);

    logic          fifo_push, fifo_pop;
    trace_ent_t    fifo_in, fifo_head;
    logic [CW-1:0] fifo_cnt;

    pkt_trace_capture #(.DEPTH(FIFO_DEPTH), .CW(CW)) cap_i (
        .clk(clk), .rst(rst),
        .tx_act(tx_act), .tx_sym_vld(tx_sym_vld), .tx_sym(tx_sym),
        .rx_act(rx_act), .rx_sym_vld(rx_sym_vld), .rx_sym(rx_sym),
        .cnt(fifo_cnt), .push(fifo_push), .ent(fifo_in)
    );

    pkt_trace_fifo #(.DEPTH(FIFO_DEPTH), .CW(CW)) fifo_i (
        .clk(clk), .rst(rst),
        .push(fifo_push), .din(fifo_in),
        .pop(fifo_pop), .dout(fifo_head), .cnt(fifo_cnt)
    );

    pkt_trace_ser #(.DIV(DIV)) ser_i (
        .clk(clk), .rst(rst),
        .empty(fifo_cnt == '0), .head(fifo_head),
        .pop(fifo_pop), .frame(trace_frame), .line(trace_data)
    );
endmodule

// File: rtl/pkt_trace_chk.sv
module pkt_trace_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push,
    input logic          pop,
    input logic [CW-1:0] cnt,
    input logic          frame,
    input logic          data
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != CW'(DEPTH))); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0)); // R9

    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame |-> data); // R1

    AST_LEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(frame) |=> data); // R3
endmodule

bind pkt_trace_port pkt_trace_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .push(fifo_push), .pop(fifo_pop),
    .cnt(fifo_cnt), .frame(trace_frame), .data(trace_data)
);

// File: tb/pkt_trace_port_tb_top.sv
module pkt_trace_port_tb_top;
    localparam int DIV   = 100;
    localparam int DEPTH = 16;
    localparam int END_M = -1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_act = 1'b0, tx_sym_vld = 1'b0, rx_act = 1'b0, rx_sym_vld = 1'b0;
    logic [3:0] tx_sym = '0, rx_sym = '0;
    logic       trace_frame, trace_data;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pkt_trace_port #(.CLK_HZ(50_000_000), .BIT_HZ(500_000), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .tx_act(tx_act), .tx_sym_vld(tx_sym_vld), .tx_sym(tx_sym),
        .rx_act(rx_act), .rx_sym_vld(rx_sym_vld), .rx_sym(rx_sym),
        .trace_frame(trace_frame), .trace_data(trace_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
                     req, act, act, exp, exp, cyc);
        end
    endtask

    function automatic int take_exp();
        if (exp_q.size() == 0) return -2;
        return exp_q.pop_front();
    endfunction

    // R5 stimulus: one tap cycle on both directions
    task automatic step(input logic tv, input logic [3:0] ts, input logic rv, input logic [3:0] rs);
        tx_sym_vld = tv; tx_sym = ts; rx_sym_vld = rv; rx_sym = rs;
        @(negedge clk);
    endtask

    function automatic logic [7:0] gen(input logic [7:0] seed, input int i);
        return seed + 8'(i * 29);
    endfunction

    // Drive one packet and queue its expected trace (R4, R5, R6, R9)
    task automatic drive_pkt(input bit is_rx, input int nbytes, input logic [7:0] seed, input bit odd);
        logic [7:0] b;
        exp_q.push_back(is_rx ? 32'h02 : 32'h01);
        for (int i = 0; i < nbytes; i++)
            if (i < DEPTH - 1) exp_q.push_back(int'(gen(seed, i)));
        if (nbytes > DEPTH - 1) exp_q.push_back(32'hEE);
        exp_q.push_back(END_M);
        if (is_rx) rx_act = 1'b1; else tx_act = 1'b1;
        @(negedge clk);
        for (int i = 0; i < nbytes; i++) begin
            b = gen(seed, i);
            if (is_rx) begin step(0, 0, 1, b[3:0]); step(0, 0, 1, b[7:4]); end
            else       begin step(1, b[3:0], 0, 0); step(1, b[7:4], 0, 0); end
        end
        if (odd) begin
            if (is_rx) step(0, 0, 1, 4'h9); else step(1, 4'h9, 0, 0);
        end
        tx_sym_vld = 1'b0; rx_sym_vld = 1'b0;
        tx_act = 1'b0; rx_act = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        while (exp_q.size() != 0 || trace_frame) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && !trace_frame && trace_data, req, exp_q.size(), 0);
    endtask

    // Monitor: decode frames and compare against the scoreboard queue
    initial begin : monitor
        int t_rise, t_start, e;
        bit first;
        logic [7:0] rb;
        forever begin
            @(negedge clk);
            if (!rst && trace_frame) begin
                t_rise = cyc; first = 1'b1; t_start = cyc;
                forever begin
                    @(negedge clk);
                    if (!trace_frame) begin
                        e = take_exp();
                        chk(e == END_M, "R3 frame end", e, END_M);
                        chk(cyc - t_start == 11 * DIV, "R3 trail", cyc - t_start, 11 * DIV);
                        break;
                    end
                    if (!trace_data) begin
                        if (first) chk(cyc - t_rise == DIV, "R3 lead", cyc - t_rise, DIV);
                        else       chk(cyc - t_start == 10 * DIV, "R2 spacing", cyc - t_start, 10 * DIV);
                        first = 1'b0;
                        t_start = cyc;
                        repeat (DIV / 2) @(negedge clk);
                        chk(trace_data == 1'b0, "R2 start bit", int'(trace_data), 0);
                        for (int i = 0; i < 8; i++) begin
                            repeat (DIV) @(negedge clk);
                            rb[i] = trace_data;
                        end
                        repeat (DIV) @(negedge clk);
                        chk(trace_data == 1'b1, "R2 stop bit", int'(trace_data), 1);
                        e = take_exp();
                        chk(e == int'(rb), "R4/R5/R9 byte", int'(rb), e);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(trace_frame == 1'b0, "R1 reset frame", int'(trace_frame), 0);
        chk(trace_data == 1'b1, "R1 reset data", int'(trace_data), 1);

        // R4 R5: transmit packet, three bytes
        drive_pkt(1'b0, 3, 8'hA5, 1'b0);
        wait_idle("R4 tx done");
        // R4: receive packet
        drive_pkt(1'b1, 2, 8'h3C, 1'b0);
        wait_idle("R4 rx done");
        // R6: odd trailing symbol discarded
        drive_pkt(1'b0, 1, 8'h7E, 1'b1);
        wait_idle("R6 odd tail");
        // R4: tag-only receive frame
        drive_pkt(1'b1, 0, 8'h00, 1'b0);
        wait_idle("R4 empty rx");

        // R7: both rise together, only transmit traced
        exp_q.push_back(32'h01); exp_q.push_back(32'hC4); exp_q.push_back(END_M);
        tx_act = 1'b1; rx_act = 1'b1;
        @(negedge clk);
        step(1, 4'h4, 1, 4'hF);
        step(1, 4'hC, 1, 4'hF);
        tx_sym_vld = 1'b0; rx_sym_vld = 1'b0; tx_act = 1'b0;
        @(negedge clk);
        step(0, 0, 1, 4'h1);
        step(0, 0, 1, 4'h2);
        rx_sym_vld = 1'b0; rx_act = 1'b0;
        @(negedge clk);
        wait_idle("R7 tx priority");

        // R8: receive starts during transmit capture and outlives it
        exp_q.push_back(32'h01); exp_q.push_back(32'h21); exp_q.push_back(32'h43); exp_q.push_back(END_M);
        tx_act = 1'b1;
        @(negedge clk);
        step(1, 4'h1, 0, 0);
        rx_act = 1'b1;
        step(1, 4'h2, 1, 4'h5);
        step(1, 4'h3, 1, 4'h6);
        step(1, 4'h4, 1, 4'h7);
        tx_sym_vld = 1'b0; tx_act = 1'b0;
        step(0, 0, 1, 4'h8);
        step(0, 0, 1, 4'h9);
        step(0, 0, 1, 4'hA);
        rx_sym_vld = 1'b0; rx_act = 1'b0;
        @(negedge clk);
        wait_idle("R8 late start ignored");

        // R9: overflow truncates and closes with error tag
        drive_pkt(1'b0, 20, 8'h11, 1'b0);
        wait_idle("R9 overflow");

        // R2: back-to-back after overflow recovery
        drive_pkt(1'b1, 4, 8'hF0, 1'b0);
        wait_idle("R2 recovery");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule